// File: doc/BRIEF.md
# Command Mailbox Engine

The block is the device side of a set of command mailboxes kept in a word-addressed register file that the host shares with the device. Each mailbox is twenty 32-bit words: a flag word, a command code, a return code, a timeout and sixteen parameter/result words. The host claims a call mailbox, fills in the command, timeout and parameters, and then marks it ready. The engine finds such mailboxes in round-robin order and passes each command to an executor over a valid/ready handshake. It writes the executor's return code and results back into the mailbox and then sets the done flag. If the host does not collect a completed mailbox within its timeout, a per-mailbox watchdog clears the mailbox header.

The mailboxes are split into two groups. The lower group is for host-issued calls. The upper group holds notification records that the device posts, with an interrupt pulse to tell the host. A fixed four-word signature sits at the start of the host address space, so software can find the mailbox area. The mailboxes start at word 4. Mailbox `b`, word `w`, is at host word address `4 + 20*b + w`.

Top module: `mbx_engine`

## Requirements
- R1: Host word addresses 0..3 read as the signature 0x12345678, 0x34567812, 0x56781234, 0x78123456 (byte order 78 56 34 12 ...), and host writes to them have no effect. A host read returns the word one clock after the address is presented.
- R2: A call mailbox (0..N_CALL-1) is serviced only when its flag word has bit 0 (claimed) and bit 1 (ready) set and bit 2 (done) clear. A mailbox with only one of bits 0 and 1 set, and any notification mailbox, is never handed to the executor.
- R3: A serviced command is presented with cmd_valid, its mailbox index on cmd_slot, word 1 on cmd_code and words 4..19 on cmd_params (word 4 in bits 31:0). These are held stable until cmd_ready, and only one command is outstanding at a time.
- R4: When rsp_valid arrives, rsp_ret is written to word 2, rsp_results to words 4..19 (bits 31:0 to word 4), and flag bit 2 is set while bits 0 and 1 are kept. The flag word then reads 7.
- R5: A command code above CMD_MAX (default 31) is never passed to the executor. It completes at once with return word 0xFFFFFFFF, done set and parameters unchanged. A code equal to CMD_MAX is executed.
- R6: Pending call mailboxes are taken in round-robin order, starting at the index after the most recently completed one.
- R7: If a done mailbox still has bit 2 set T+1 clocks after completion (T = low TMR_W bits of word 3), words 0..3 of that mailbox are cleared. Result words 4..19 are kept.
- R8: If the host clears bit 2 before the timeout expires, the watchdog for that mailbox stops, and the header is not cleared later.
- R9: An event with evt_valid and evt_slot e writes evt_data to words 4..19 of mailbox N_CALL+e and leaves its words 0..3 unchanged. evt_irq is high for exactly the one clock that follows.
- R10: After reset, every mailbox word reads 0, and cmd_valid and evt_irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W (9) | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one clock after the address |
| cmd_valid | output | 1 | Command offered to the executor |
| cmd_ready | input | 1 | Executor accepts the command |
| cmd_slot | output | SLOT_W (4) | Call mailbox index of the command |
| cmd_code | output | 32 | Command code |
| cmd_params | output | 512 | Sixteen parameter words |
| rsp_valid | input | 1 | Executor response strobe |
| rsp_ret | input | 32 | Return code from the executor |
| rsp_results | input | 512 | Sixteen result words |
| evt_valid | input | 1 | Post a notification record |
| evt_slot | input | EVT_W (4) | Notification mailbox index |
| evt_data | input | 512 | Sixteen notification words |
| evt_irq | output | 1 | One-clock notification interrupt |

## Verification
Every call mailbox is issued on its own first, which shows that the mailbox index, code and parameters reach the executor and that the results come back to the right words. Command codes of 31, 32 and 0xFFFFFFFF separate the executed path from the immediate undefined-code completion. All ten mailboxes are then armed at once, in a rotated order, after slot 4 was the last one served. Only a round-robin picker gives the order 5..9, 0..4; a fixed-priority picker does not. Timeouts of 0, 1, 2 and 5 are read back cycle by cycle to place the clearing edge exactly. An early host clear shows that the watchdog stops. Partially flagged mailboxes and a flagged notification mailbox must stay untouched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W    = 32;
  localparam int HDR_WORDS = 4;

  // header word positions inside a mailbox
  localparam int IDX_FLAGS = 0;
  localparam int IDX_CMD   = 1;
  localparam int IDX_RET   = 2;
  localparam int IDX_TMO   = 3;

  // flag bits
  localparam int BIT_CLAIM = 0;
  localparam int BIT_READY = 1;
  localparam int BIT_DONE  = 2;

  localparam logic [WORD_W-1:0] DONE_MASK = WORD_W'(1) << BIT_DONE;
  localparam logic [WORD_W-1:0] RET_UNDEF = '1;
  localparam logic [WORD_W-1:0] SIG_SEED  = 32'h1234_5678;

  typedef enum logic [1:0] {ENG_SCAN, ENG_ISSUE, ENG_WAIT} eng_state_t;

  // signature word k is the seed rotated left by 8*k bits
  function automatic logic [WORD_W-1:0] sig_word(input int unsigned k);
    logic [2*WORD_W-1:0] dbl;
    dbl = {SIG_SEED, SIG_SEED};
    return dbl[2*WORD_W-1-8*(k%4) -: WORD_W];
  endfunction
endpackage

// File: rtl/mbx_rr_pick.sv
module mbx_rr_pick #(
  parameter  int N  = 10,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);
  // search starts one past the last serviced index and wraps
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int off = 1; off <= N; off++) begin
      int cand;
      cand = (int'(last) + off) % N;
      if (!found && req[cand]) begin
        found = 1'b1;
        pick  = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/mbx_tmo_bank.sv
module mbx_tmo_bank #(
  parameter int N     = 10,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     load,
  input  logic [N*TMR_W-1:0] load_val,
  input  logic [N-1:0]     done,
  output logic [N-1:0]     expire
);
  for (genvar i = 0; i < N; i++) begin : g_tmr
    logic             armed;
    logic [TMR_W-1:0] cnt;

    assign expire[i] = armed && done[i] && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (load[i]) begin
        armed <= 1'b1;
        cnt   <= load_val[i*TMR_W +: TMR_W];
      end else if (armed) begin
        if (!done[i] || cnt == '0) armed <= 1'b0;
        else                       cnt   <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter  int N_CALL  = 10,
  parameter  int N_EVT   = 10,
  parameter  int N_PARAM = 16,
  parameter  int TMR_W   = 16,
  parameter  logic [WORD_W-1:0] CMD_MAX = 32'd31,
  localparam int SIG_WORDS = 4,
  localparam int BOX_WORDS = HDR_WORDS + N_PARAM,
  localparam int N_BOX     = N_CALL + N_EVT,
  localparam int MEM_WORDS = N_BOX * BOX_WORDS,
  localparam int ADDR_W    = $clog2(SIG_WORDS + MEM_WORDS),
  localparam int MIDX_W    = $clog2(MEM_WORDS),
  localparam int SLOT_W    = (N_CALL > 1) ? $clog2(N_CALL) : 1,
  localparam int EVT_W     = (N_EVT > 1) ? $clog2(N_EVT) : 1,
  localparam int PAR_BITS  = N_PARAM * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [WORD_W-1:0]   host_wdata,
  output logic [WORD_W-1:0]   host_rdata,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [SLOT_W-1:0]   cmd_slot,
  output logic [WORD_W-1:0]   cmd_code,
  output logic [PAR_BITS-1:0] cmd_params,
  input  logic                rsp_valid,
  input  logic [WORD_W-1:0]   rsp_ret,
  input  logic [PAR_BITS-1:0] rsp_results,
  input  logic                evt_valid,
  input  logic [EVT_W-1:0]    evt_slot,
  input  logic [PAR_BITS-1:0] evt_data,
  output logic                evt_irq
);
  // flat word index of (mailbox, word)
  function automatic logic [MIDX_W-1:0] wix(input int box, input int w);
    return MIDX_W'(box * BOX_WORDS + w);
  endfunction

  logic [WORD_W-1:0] mem [MEM_WORDS];

  // ---------------- named internal events ----------------
  logic [N_CALL-1:0]       pend_vec;
  logic [N_CALL-1:0]       done_vec;
  logic                    found;
  logic [SLOT_W-1:0]       pick;
  logic [WORD_W-1:0]       pick_code;
  logic                    pick_undef;
  logic                    scan_fire;
  logic                    undef_fire;
  logic                    issue_start;
  logic                    rsp_fire;
  logic                    complete_fire;
  logic [SLOT_W-1:0]       done_slot;
  logic [N_CALL-1:0]       tmo_load;
  logic [N_CALL*TMR_W-1:0] tmo_val;
  logic [N_CALL-1:0]       tmo_expire;
  logic                    evt_ok;
  logic                    host_in_box;
  logic [MIDX_W-1:0]       host_idx;

  eng_state_t        state;
  logic [SLOT_W-1:0] cur_slot;
  logic [SLOT_W-1:0] last_slot;
  logic [WORD_W-1:0] code_q;

  always_comb begin
    for (int i = 0; i < N_CALL; i++) begin
      pend_vec[i] = mem[wix(i, IDX_FLAGS)][BIT_CLAIM] &
                    mem[wix(i, IDX_FLAGS)][BIT_READY] &
                    ~mem[wix(i, IDX_FLAGS)][BIT_DONE];
      done_vec[i] = mem[wix(i, IDX_FLAGS)][BIT_DONE];
    end
  end

  mbx_rr_pick #(.N(N_CALL)) u_pick (
    .req   (pend_vec),
    .last  (last_slot),
    .found (found),
    .pick  (pick)
  );

  assign pick_code     = mem[wix(int'(pick), IDX_CMD)];
  assign pick_undef    = pick_code > CMD_MAX;
  assign scan_fire     = (state == ENG_SCAN) && found;
  assign undef_fire    = scan_fire && pick_undef;
  assign issue_start   = scan_fire && !pick_undef;
  assign rsp_fire      = (state == ENG_WAIT) && rsp_valid;
  assign complete_fire = undef_fire || rsp_fire;
  assign done_slot     = undef_fire ? pick : cur_slot;
  assign evt_ok        = evt_valid && (int'(evt_slot) < N_EVT);

  always_comb begin
    for (int i = 0; i < N_CALL; i++) begin
      tmo_load[i] = complete_fire && (int'(done_slot) == i);
      tmo_val[i*TMR_W +: TMR_W] = mem[wix(i, IDX_TMO)][TMR_W-1:0];
    end
  end

  mbx_tmo_bank #(.N(N_CALL), .TMR_W(TMR_W)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmo_load),
    .load_val (tmo_val),
    .done     (done_vec),
    .expire   (tmo_expire)
  );

  // ---------------- executor side ----------------
  assign cmd_valid = (state == ENG_ISSUE);
  assign cmd_slot  = cur_slot;
  assign cmd_code  = code_q;
  always_comb begin
    for (int p = 0; p < N_PARAM; p++)
      cmd_params[p*WORD_W +: WORD_W] = mem[wix(int'(cur_slot), HDR_WORDS + p)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_SCAN;
      cur_slot  <= '0;
      last_slot <= SLOT_W'(N_CALL - 1);
      code_q    <= '0;
    end else begin
      unique case (state)
        ENG_SCAN: begin
          if (undef_fire) last_slot <= pick;
          if (issue_start) begin
            cur_slot <= pick;
            code_q   <= pick_code;
            state    <= ENG_ISSUE;
          end
        end
        ENG_ISSUE: if (cmd_ready) state <= ENG_WAIT;
        ENG_WAIT: begin
          if (rsp_valid) begin
            last_slot <= cur_slot;
            state     <= ENG_SCAN;
          end
        end
        default: state <= ENG_SCAN;
      endcase
    end
  end

  // ---------------- shared register file ----------------
  assign host_in_box = (int'(host_addr) >= SIG_WORDS) &&
                       (int'(host_addr) < SIG_WORDS + MEM_WORDS);
  assign host_idx    = MIDX_W'(int'(host_addr) - SIG_WORDS);

  // device updates follow the host write, so the device wins a collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MEM_WORDS; k++) mem[k] <= '0;
    end else begin
      if (host_we && host_in_box) mem[host_idx] <= host_wdata;
      if (evt_ok) begin
        for (int p = 0; p < N_PARAM; p++)
          mem[wix(N_CALL + int'(evt_slot), HDR_WORDS + p)] <= evt_data[p*WORD_W +: WORD_W];
      end
      if (undef_fire) begin
        mem[wix(int'(pick), IDX_RET)]   <= RET_UNDEF;
        mem[wix(int'(pick), IDX_FLAGS)] <= mem[wix(int'(pick), IDX_FLAGS)] | DONE_MASK;
      end
      if (rsp_fire) begin
        mem[wix(int'(cur_slot), IDX_RET)]   <= rsp_ret;
        mem[wix(int'(cur_slot), IDX_FLAGS)] <= mem[wix(int'(cur_slot), IDX_FLAGS)] | DONE_MASK;
        for (int p = 0; p < N_PARAM; p++)
          mem[wix(int'(cur_slot), HDR_WORDS + p)] <= rsp_results[p*WORD_W +: WORD_W];
      end
      for (int i = 0; i < N_CALL; i++) begin
        if (tmo_expire[i]) begin
          for (int w = 0; w < HDR_WORDS; w++) mem[wix(i, w)] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      evt_irq    <= 1'b0;
    end else begin
      evt_irq <= evt_ok;
      if (int'(host_addr) < SIG_WORDS) host_rdata <= sig_word(32'(host_addr));
      else if (host_in_box)            host_rdata <= mem[host_idx];
      else                             host_rdata <= '0;
    end
  end
endmodule

// File: rtl/mbx_engine_chk.sv
module mbx_engine_chk #(
  parameter int          SLOT_W  = 4,
  parameter int          N_CALL  = 10,
  parameter logic [31:0] CMD_MAX = 32'd31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [SLOT_W-1:0] cmd_slot,
  input logic [31:0]       cmd_code,
  input logic              rsp_fire,
  input logic [SLOT_W-1:0] cur_slot,
  input logic [N_CALL-1:0] done_vec,
  input logic              evt_ok,
  input logic              evt_irq
);
  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_slot) && $stable(cmd_code)));

  assert_call_slot_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (int'(cmd_slot) < N_CALL));

  assert_defined_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code <= CMD_MAX));

  assert_done_after_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> done_vec[cur_slot]);

  assert_irq_follows_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ok |=> evt_irq);

  assert_irq_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq |-> $past(evt_ok));
endmodule

bind mbx_engine mbx_engine_chk #(
  .SLOT_W  (SLOT_W),
  .N_CALL  (N_CALL),
  .CMD_MAX (CMD_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_slot  (cmd_slot),
  .cmd_code  (cmd_code),
  .rsp_fire  (rsp_fire),
  .cur_slot  (cur_slot),
  .done_vec  (done_vec),
  .evt_ok    (evt_ok),
  .evt_irq   (evt_irq)
);

// File: tb/mbx_engine_tb.sv
module mbx_engine_tb;
  localparam int NC = 10, NE = 10, NP = 16, BW = 20, SIGW = 4;
  localparam logic [31:0] CMAX = 32'd31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         host_we = 1'b0;
  logic [8:0]   host_addr = '0;
  logic [31:0]  host_wdata = '0;
  logic [31:0]  host_rdata;
  logic         cmd_valid;
  logic         cmd_ready = 1'b0;
  logic [3:0]   cmd_slot;
  logic [31:0]  cmd_code;
  logic [511:0] cmd_params;
  logic         rsp_valid = 1'b0;
  logic [31:0]  rsp_ret = '0;
  logic [511:0] rsp_results = '0;
  logic         evt_valid = 1'b0;
  logic [3:0]   evt_slot = '0;
  logic [511:0] evt_data = '0;
  logic         evt_irq;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, vcount = 0, done_cyc = 0, rd_cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cmd_valid) vcount <= vcount + 1;
  end

  mbx_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_slot(cmd_slot),
    .cmd_code(cmd_code), .cmd_params(cmd_params),
    .rsp_valid(rsp_valid), .rsp_ret(rsp_ret), .rsp_results(rsp_results),
    .evt_valid(evt_valid), .evt_slot(evt_slot), .evt_data(evt_data), .evt_irq(evt_irq)
  );

  function automatic logic [8:0] ba(input int b, input int w);
    return 9'(SIGW + b * BW + w);
  endfunction
  function automatic logic [31:0] par_pat(input int s, input int k);
    return 32'h1000_0000 + 32'(s) * 32'h100 + 32'(k) * 3;
  endfunction
  function automatic logic [31:0] ex_ret(input logic [31:0] code);
    return code ^ 32'h0000_A5A5;
  endfunction
  function automatic logic [31:0] ex_res(input logic [31:0] code, input logic [31:0] p, input int k);
    return p + code + 32'(k);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    host_we = 1'b0; host_addr = a;
    @(posedge clk);
    #1;
    d = host_rdata;
    rd_cyc = cyc;
  endtask

  task automatic load_call(input int s, input logic [31:0] code, input logic [31:0] tmo);
    hwrite(ba(s, 1), code);
    hwrite(ba(s, 3), tmo);
    for (int k = 0; k < NP; k++) hwrite(ba(s, 4 + k), par_pat(s, k));
  endtask

  // executor model: accept one command, answer two clocks later
  task automatic serve_one(output int slot, output logic [31:0] code, output logic [31:0] p0);
    int waitc = 0;
    slot = -1; code = '0; p0 = '0;
    @(negedge clk);
    while (!cmd_valid && waitc < 200) begin
      @(negedge clk);
      waitc++;
    end
    if (!cmd_valid) return;
    slot = int'(cmd_slot);
    code = cmd_code;
    p0   = cmd_params[31:0];
    for (int k = 0; k < NP; k++)
      rsp_results[k*32 +: 32] = ex_res(cmd_code, cmd_params[k*32 +: 32], k);
    rsp_ret = ex_ret(cmd_code);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    @(negedge clk);
    rsp_valid = 1'b1;
    @(posedge clk);
    #1;
    done_cyc = cyc;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic wait_done(input int s, output logic [31:0] f);
    f = '0;
    for (int n = 0; n < 60; n++) begin
      hread(ba(s, 0), f);
      if (f[2]) break;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10: watchdog actual hung expected completion");
    summary();
  end

  initial begin
    logic [31:0] d, f, code, p0;
    int slot, v0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check("R10 rdata", host_rdata, 32'h0);
    check("R10 cmd_valid", 32'(cmd_valid), 32'h0);
    check("R10 evt_irq", 32'(evt_irq), 32'h0);
    hread(ba(0, 0), d);  check("R10 flags", d, 32'h0);
    hread(ba(19, 19), d); check("R10 last word", d, 32'h0);

    // R1 signature and write protection
    for (int k = 0; k < 4; k++) begin
      logic [63:0] dd;
      dd = {32'h1234_5678, 32'h1234_5678};
      hread(9'(k), d);
      check("R1 signature", d, dd[63-8*k -: 32]);
    end
    hwrite(9'd0, 32'hDEAD_BEEF);
    hread(9'd0, d); check("R1 write ignored", d, 32'h1234_5678);

    // R3/R4 each call mailbox on its own
    for (int s = 0; s < NC; s++) begin
      logic [31:0] c;
      c = 32'(s + 1);
      load_call(s, c, 32'd1000);
      hwrite(ba(s, 0), 32'h3);
      serve_one(slot, code, p0);
      check("R3 slot", 32'(slot), 32'(s));
      check("R3 code", code, c);
      check("R3 param0", p0, par_pat(s, 0));
      wait_done(s, f);
      check("R4 flags", f, 32'h7);
      hread(ba(s, 2), d); check("R4 return", d, ex_ret(c));
      for (int k = 0; k < NP; k++) begin
        hread(ba(s, 4 + k), d);
        check("R4 result", d, ex_res(c, par_pat(s, k), k));
      end
      hwrite(ba(s, 0), 32'h0);
    end

    // R5 undefined codes
    v0 = vcount;
    load_call(2, CMAX + 1, 32'd1000);
    hwrite(ba(2, 0), 32'h3);
    wait_done(2, f);
    check("R5 flags", f, 32'h7);
    hread(ba(2, 2), d); check("R5 return", d, 32'hFFFF_FFFF);
    hread(ba(2, 4), d); check("R5 params kept", d, par_pat(2, 0));
    load_call(3, 32'hFFFF_FFFF, 32'd1000);
    hwrite(ba(3, 0), 32'h3);
    wait_done(3, f);
    check("R5 flags max", f, 32'h7);
    hread(ba(3, 2), d); check("R5 return max", d, 32'hFFFF_FFFF);
    check("R5 executor idle", 32'(vcount - v0), 32'h0);
    load_call(4, CMAX, 32'd1000);
    hwrite(ba(4, 0), 32'h3);
    serve_one(slot, code, p0);
    check("R5 boundary slot", 32'(slot), 32'd4);
    check("R5 boundary code", code, CMAX);
    wait_done(4, f);
    hread(ba(4, 2), d); check("R5 boundary return", d, ex_ret(CMAX));
    for (int s = 2; s < 5; s++) hwrite(ba(s, 0), 32'h0);

    // R6 round robin: last completed is slot 4
    for (int s = 0; s < NC; s++) load_call(s, 32'(20 + s), 32'd2000);
    for (int j = 0; j < NC; j++) hwrite(ba((5 + j) % NC, 0), 32'h3);
    for (int j = 0; j < NC; j++) begin
      serve_one(slot, code, p0);
      check("R6 order", 32'(slot), 32'((5 + j) % NC));
    end
    for (int s = 0; s < NC; s++) begin
      wait_done(s, f);
      check("R6 all done", f, 32'h7);
      hwrite(ba(s, 0), 32'h0);
    end

    // R2 partial flags and notification mailbox never serviced
    v0 = vcount;
    hwrite(ba(1, 0), 32'h1);
    hwrite(ba(6, 0), 32'h2);
    hwrite(ba(12, 0), 32'h3);
    repeat (30) @(posedge clk);
    check("R2 executor idle", 32'(vcount - v0), 32'h0);
    hread(ba(1, 0), d);  check("R2 claim only", d, 32'h1);
    hread(ba(6, 0), d);  check("R2 ready only", d, 32'h2);
    hread(ba(12, 0), d); check("R2 notify box", d, 32'h3);
    hwrite(ba(1, 0), 32'h0);
    hwrite(ba(6, 0), 32'h0);
    hwrite(ba(12, 0), 32'h0);

    // R7 timeout placement, cleared T+1 clocks after completion
    foreach (tlist[i]) begin
      int t;
      t = tlist[i];
      load_call(7, 32'd3, 32'(t));
      hwrite(ba(7, 0), 32'h3);
      serve_one(slot, code, p0);
      for (int n = 0; n < t + 4; n++) begin
        hread(ba(7, 0), d);
        check("R7 flags timeline", d, ((rd_cyc - done_cyc) >= t + 2) ? 32'h0 : 32'h7);
      end
      hread(ba(7, 1), d); check("R7 cmd cleared", d, 32'h0);
      hread(ba(7, 3), d); check("R7 tmo cleared", d, 32'h0);
      hread(ba(7, 4), d); check("R7 results kept", d, ex_res(32'd3, par_pat(7, 0), 0));
    end

    // R8 host collects in time: watchdog stops
    load_call(8, 32'd9, 32'd4);
    hwrite(ba(8, 0), 32'h3);
    serve_one(slot, code, p0);
    hwrite(ba(8, 0), 32'h0);
    repeat (20) @(posedge clk);
    hread(ba(8, 1), d); check("R8 cmd kept", d, 32'd9);
    hread(ba(8, 3), d); check("R8 tmo kept", d, 32'd4);

    // R9 notification records
    for (int e = 0; e < NE; e++) begin
      hwrite(ba(NC + e, 0), 32'h5);
      hwrite(ba(NC + e, 1), 32'hC0DE_0000 + 32'(e));
      @(negedge clk);
      evt_valid = 1'b1;
      evt_slot  = 4'(e);
      for (int k = 0; k < NP; k++) evt_data[k*32 +: 32] = 32'hE000_0000 + 32'(e * 64 + k);
      @(posedge clk);
      #1;
      check("R9 irq high", 32'(evt_irq), 32'h1);
      @(negedge clk);
      evt_valid = 1'b0;
      @(posedge clk);
      #1;
      check("R9 irq one clock", 32'(evt_irq), 32'h0);
      for (int k = 0; k < NP; k++) begin
        hread(ba(NC + e, 4 + k), d);
        check("R9 data", d, 32'hE000_0000 + 32'(e * 64 + k));
      end
      hread(ba(NC + e, 0), d); check("R9 flags untouched", d, 32'h5);
      hread(ba(NC + e, 1), d); check("R9 cmd untouched", d, 32'hC0DE_0000 + 32'(e));
    end

    summary();
  end

  int tlist [4] = '{0, 1, 2, 5};
endmodule